// File: doc/BRIEF.md
# Chip Erase Sequencer

This block sits on the programmer side of an electrically erasable parallel memory. It runs a complete whole-array erase. Before each erase pulse it asserts two high-voltage select lines, one for the combined output-enable/programming-supply pin and one for address line 9. It then holds the chip-select low for a timed pulse. After the pulse it removes the high voltages and drops the core supply to its reduced level. It then reads the array back byte by byte, expecting every byte to be all ones.

When a byte fails, the block applies another erase pulse and resumes reading at that same byte. The number of pulses is limited. Once every byte has passed at reduced supply, the block restores the normal supply and reads the whole array once more. The run ends with a sticky pass or fail result.

The analog supplies are outside the block. It only produces the select lines and the strobes. Every interval is given in nanoseconds and turned into clock cycles from a clock-frequency parameter.

Top module: `erase_seq`

## Requirements
- R1: In reset and after reset until `start`, all outputs are idle. The high-voltage selects, `vcc_low_sel`, `dq_out_en` and `busy` are 0. `ce_n` and `oe_n` are 1. `addr` and `dq_out` are zero. `done`, `pass` and `fail` are 0, and `pulse_cnt` is 0.
- R2: Every interval lasts N = ceil(T_ns × CLK_HZ / 1e9) cycles, with a minimum of 1. A pulse is always preceded by a setup interval of N_SETUP cycles. During setup, `hv_vpp_en` and `hv_a9_en` are 1, `addr` is all zeros, `dq_out` is all ones with `dq_out_en`=1, `vcc_low_sel` is 0 and `ce_n` is 1.
- R3: The erase pulse holds `ce_n` at 0 for exactly N_PULSE cycles, with the setup levels unchanged. `pulse_cnt` increments by one in the first pulse cycle.
- R4: After `ce_n` returns high, the high-voltage selects, the zero address and the driven data stay in place for N_HOLD cycles. Then, for another N_HOLD cycles, all of them are off, `vcc_low_sel` is 1 and `ce_n`/`oe_n` are 1.
- R5: A high-voltage select is never 1 while `vcc_low_sel` is 1.
- R6: Verify runs with `vcc_low_sel`=1, `ce_n`=0 and `oe_n`=0, and no data is driven. Each address is presented for N_VACC cycles and `dq_in` is sampled in the last of them. Addresses advance upward while bytes read as all ones.
- R7: When a verify byte is not all ones and fewer than MAX_PULSES pulses have been applied, a new setup/pulse/hold/recovery sequence runs. Verify then resumes at the failing address.
- R8: When a verify byte fails and `pulse_cnt` equals MAX_PULSES, the run ends with `done`=1 and `fail`=1. `pulse_cnt` never exceeds MAX_PULSES.
- R9: After the highest address passes verify, a final read runs from address 0 at normal supply, with `ce_n`=`oe_n`=0 and N_NACC cycles per address. The first byte that is not all ones ends the run with `fail`=1. If all bytes pass, the run ends with `pass`=1.
- R10: In the done state, `done`, `pass`, `fail` and `pulse_cnt` hold until the next `start`. That `start` clears the flags in the first setup cycle. A `start` while `busy` has no effect.
- R11: When `abort` is 1 while `busy`, then in the next cycle both high-voltage selects are 0, `ce_n` is 1 and `done`=`fail`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an erase run (accepted when not busy) |
| abort | input | 1 | Stop the run and drop high voltage |
| dq_in | input | DATA_W | Data read back from the memory |
| hv_vpp_en | output | 1 | Select erase-level voltage on the output-enable/supply pin |
| hv_a9_en | output | 1 | Select erase-level voltage on address line 9 |
| vcc_low_sel | output | 1 | Select reduced core supply for verify |
| ce_n | output | 1 | Chip select, active low; erase pulse strobe |
| oe_n | output | 1 | Output enable, active low (logic level) |
| addr | output | ADDR_W | Address lines |
| dq_out | output | DATA_W | Data driven to the memory during erase setup |
| dq_out_en | output | 1 | Drive enable for `dq_out` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Sticky: run finished |
| pass | output | 1 | Sticky: array erased and checked |
| fail | output | 1 | Sticky: limit reached, final check failed or aborted |
| pulse_cnt | output | PC_W | Erase pulses applied in this run |

## Verification
The hardest case to reach is a resumed verify: a byte that fails after one or more pulses while earlier bytes have already passed, followed by a run that hits the pulse limit. Both depend on how the memory responds rather than on the block's own inputs. The bench therefore contains a memory model that counts the erase pulses it has received and returns all ones for an address only once that count reaches a per-address threshold set by each scenario. Another scenario marks one address as weak at normal supply only, so the run reaches the final read and fails there.

// File: rtl/erase_seq_pkg.sv
// Shared types and the time-to-cycle conversion for the erase sequencer.
// Assumes the clock frequency is given in Hz and all intervals in ns.
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOV,
        ST_VFY,
        ST_FINAL,
        ST_DONE
    } erase_state_e;

    // Round an interval up to whole clock cycles, never below one cycle.
    function automatic longint unsigned cyc_from_ns(input longint unsigned t_ns,
                                                    input longint unsigned clk_hz);
        longint unsigned c;
        c = (t_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/erase_timer.sv
// Interval timer: loaded with (cycles-1) on entry to a timed phase,
// counts down to zero and stays there. zero marks the last cycle.
// Assumes the controller reloads it on every phase change.
module erase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Down counter with synchronous load.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/erase_addr_ctr.sv
// Verify address counter. Cleared at the start of a run and before the
// final read; it is left untouched across re-erase pulses so that verify
// resumes at the failing byte.
module erase_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] vaddr,
    output logic          last
);
    // Address register: clear wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    vaddr <= '0;
        else if (clr)  vaddr <= '0;
        else if (inc)  vaddr <= vaddr + 1'b1;
    end

    assign last = (vaddr == {AW{1'b1}});
endmodule

// File: rtl/erase_pulse_ctr.sv
// Counts erase pulses applied in the current run and flags the limit.
// Assumes the controller never increments past the limit.
module erase_pulse_ctr #(
    parameter int MAXP = 20,
    parameter int PW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [PW-1:0] count,
    output logic          at_limit
);
    localparam logic [PW-1:0] LIMIT = PW'(MAXP);

    // Pulse tally, cleared only by a new run.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (inc)  count <= count + 1'b1;
    end

    assign at_limit = (count == LIMIT);
endmodule

// File: rtl/erase_seq_ctrl.sv
// Sequencing state machine: setup, pulse, hold, recovery, reduced-supply
// verify with retry, final read at normal supply, and sticky result flags.
// Assumes byte_ok reflects the byte at the presented address in the
// cycle where the timer is at zero.
module erase_seq_ctrl
    import erase_seq_pkg::*;
#(
    parameter int          TMR_W   = 8,
    parameter int unsigned SU_CYC  = 1,
    parameter int unsigned PW_CYC  = 1,
    parameter int unsigned HD_CYC  = 1,
    parameter int unsigned AV_CYC  = 1,
    parameter int unsigned AN_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tmr_zero,
    input  logic             addr_last,
    input  logic             at_limit,
    input  logic             byte_ok,
    output erase_state_e     st,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             addr_clr,
    output logic             addr_inc,
    output logic             pc_clr,
    output logic             pc_inc,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fail
);
    localparam logic [TMR_W-1:0] L_SU = TMR_W'(SU_CYC - 1);
    localparam logic [TMR_W-1:0] L_PW = TMR_W'(PW_CYC - 1);
    localparam logic [TMR_W-1:0] L_HD = TMR_W'(HD_CYC - 1);
    localparam logic [TMR_W-1:0] L_AV = TMR_W'(AV_CYC - 1);
    localparam logic [TMR_W-1:0] L_AN = TMR_W'(AN_CYC - 1);

    erase_state_e nxt;
    logic         set_pass, set_fail, clr_flags;

    assign busy = (st != ST_IDLE) && (st != ST_DONE);

    // Next-state and datapath strobes.
    always_comb begin
        nxt       = st;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        addr_clr  = 1'b0;
        addr_inc  = 1'b0;
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        set_pass  = 1'b0;
        set_fail  = 1'b0;
        clr_flags = 1'b0;
        if (busy && abort) begin
            nxt      = ST_DONE;
            set_fail = 1'b1;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        nxt       = ST_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = L_SU;
                        addr_clr  = 1'b1;
                        pc_clr    = 1'b1;
                        clr_flags = 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tmr_zero) begin
                        nxt      = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = L_PW;
                        pc_inc   = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tmr_zero) begin
                        nxt      = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = L_HD;
                    end
                end
                ST_HOLD: begin
                    if (tmr_zero) begin
                        nxt      = ST_RECOV;
                        tmr_load = 1'b1;
                        tmr_val  = L_HD;
                    end
                end
                ST_RECOV: begin
                    if (tmr_zero) begin
                        nxt      = ST_VFY;
                        tmr_load = 1'b1;
                        tmr_val  = L_AV;
                    end
                end
                ST_VFY: begin
                    if (tmr_zero) begin
                        if (byte_ok) begin
                            tmr_load = 1'b1;
                            if (addr_last) begin
                                nxt      = ST_FINAL;
                                tmr_val  = L_AN;
                                addr_clr = 1'b1;
                            end else begin
                                tmr_val  = L_AV;
                                addr_inc = 1'b1;
                            end
                        end else if (at_limit) begin
                            nxt      = ST_DONE;
                            set_fail = 1'b1;
                        end else begin
                            nxt      = ST_SETUP;
                            tmr_load = 1'b1;
                            tmr_val  = L_SU;
                        end
                    end
                end
                ST_FINAL: begin
                    if (tmr_zero) begin
                        if (!byte_ok) begin
                            nxt      = ST_DONE;
                            set_fail = 1'b1;
                        end else if (addr_last) begin
                            nxt      = ST_DONE;
                            set_pass = 1'b1;
                        end else begin
                            tmr_load = 1'b1;
                            tmr_val  = L_AN;
                            addr_inc = 1'b1;
                        end
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Sticky result flags, cleared only by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flags) begin
            done <= 1'b0;
            pass <= 1'b0;
            fail <= 1'b0;
        end else if (set_fail) begin
            done <= 1'b1;
            fail <= 1'b1;
        end else if (set_pass) begin
            done <= 1'b1;
            pass <= 1'b1;
        end
    end
endmodule

// File: rtl/erase_seq.sv
// Top of the chip erase sequencer. Converts the timing parameters into
// cycle counts, instantiates timer, counters and controller, and decodes
// the pin-level select lines from the controller state.
// Assumes the external supplies follow the select lines within a cycle.
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 250_000_000,
    parameter longint unsigned T_PULSE_NS = 100_000_000,
    parameter longint unsigned T_SETUP_NS = 2_000,
    parameter longint unsigned T_HOLD_NS  = 2_000,
    parameter longint unsigned T_VACC_NS  = 250,
    parameter longint unsigned T_NACC_NS  = 120,
    parameter int              ADDR_W     = 16,
    parameter int              DATA_W     = 8,
    parameter int              MAX_PULSES = 20,
    localparam int             PC_W       = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] dq_in,
    output logic              hv_vpp_en,
    output logic              hv_a9_en,
    output logic              vcc_low_sel,
    output logic              ce_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_out_en,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [PC_W-1:0]   pulse_cnt
);
    localparam int unsigned SU_CYC    = int'(cyc_from_ns(T_SETUP_NS, CLK_HZ));
    localparam int unsigned PULSE_CYC = int'(cyc_from_ns(T_PULSE_NS, CLK_HZ));
    localparam int unsigned HD_CYC    = int'(cyc_from_ns(T_HOLD_NS,  CLK_HZ));
    localparam int unsigned AV_CYC    = int'(cyc_from_ns(T_VACC_NS,  CLK_HZ));
    localparam int unsigned AN_CYC    = int'(cyc_from_ns(T_NACC_NS,  CLK_HZ));
    localparam int unsigned M1        = (SU_CYC > PULSE_CYC) ? SU_CYC : PULSE_CYC;
    localparam int unsigned M2        = (HD_CYC > AV_CYC) ? HD_CYC : AV_CYC;
    localparam int unsigned M3        = (M1 > M2) ? M1 : M2;
    localparam int unsigned MAX_CYC   = (M3 > AN_CYC) ? M3 : AN_CYC;
    localparam int          TMR_W     = $clog2(MAX_CYC + 1);

    erase_state_e      st;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              addr_clr, addr_inc, addr_last;
    logic [ADDR_W-1:0] vaddr;
    logic              pc_clr, pc_inc, at_limit;
    logic              byte_ok;

    assign byte_ok = (dq_in == {DATA_W{1'b1}});

    erase_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    erase_addr_ctr #(.AW(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .vaddr (vaddr),
        .last  (addr_last)
    );

    erase_pulse_ctr #(.MAXP(MAX_PULSES), .PW(PC_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pc_clr),
        .inc      (pc_inc),
        .count    (pulse_cnt),
        .at_limit (at_limit)
    );

    erase_seq_ctrl #(
        .TMR_W  (TMR_W),
        .SU_CYC (SU_CYC),
        .PW_CYC (PULSE_CYC),
        .HD_CYC (HD_CYC),
        .AV_CYC (AV_CYC),
        .AN_CYC (AN_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .tmr_zero  (tmr_zero),
        .addr_last (addr_last),
        .at_limit  (at_limit),
        .byte_ok   (byte_ok),
        .st        (st),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .addr_clr  (addr_clr),
        .addr_inc  (addr_inc),
        .pc_clr    (pc_clr),
        .pc_inc    (pc_inc),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail      (fail)
    );

    // Pin-level decode of the current phase.
    always_comb begin
        hv_vpp_en   = 1'b0;
        hv_a9_en    = 1'b0;
        vcc_low_sel = 1'b0;
        ce_n        = 1'b1;
        oe_n        = 1'b1;
        dq_out_en   = 1'b0;
        addr        = '0;
        case (st)
            ST_SETUP, ST_HOLD: begin
                hv_vpp_en = 1'b1;
                hv_a9_en  = 1'b1;
                dq_out_en = 1'b1;
            end
            ST_PULSE: begin
                hv_vpp_en = 1'b1;
                hv_a9_en  = 1'b1;
                dq_out_en = 1'b1;
                ce_n      = 1'b0;
            end
            ST_RECOV: vcc_low_sel = 1'b1;
            ST_VFY: begin
                vcc_low_sel = 1'b1;
                ce_n        = 1'b0;
                oe_n        = 1'b0;
                addr        = vaddr;
            end
            ST_FINAL: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
                addr = vaddr;
            end
            default: ;
        endcase
    end

    assign dq_out = {DATA_W{dq_out_en}};
endmodule

// File: rtl/erase_seq_chk.sv
// Protocol checker for the erase sequencer, bound to every instance.
// Assumes ports carry the top-level pin values; counts pulse width itself.
module erase_seq_chk #(
    parameter int unsigned PULSE_CYC  = 1,
    parameter int          MAX_PULSES = 20,
    parameter int          PC_W       = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            abort,
    input logic            hv_vpp_en,
    input logic            hv_a9_en,
    input logic            vcc_low_sel,
    input logic            ce_n,
    input logic            oe_n,
    input logic            dq_out_en,
    input logic            busy,
    input logic            done,
    input logic            pass,
    input logic            fail,
    input logic [PC_W-1:0] pulse_cnt
);
    localparam int RW = $clog2(PULSE_CYC + 2);
    logic [RW-1:0] low_run;

    // Length of the current high-voltage chip-select low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_run <= '0;
        else if (!ce_n && hv_vpp_en) begin
            if (low_run != {RW{1'b1}})       low_run <= low_run + 1'b1;
        end else                             low_run <= '0;
    end

    AST_SUPPLY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_vpp_en || hv_a9_en) |-> !vcc_low_sel);                          // R5
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce_n) && hv_vpp_en) |-> ($past(hv_vpp_en) && $past(hv_a9_en))); // R2
    AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_n) && $past(hv_vpp_en) && !$past(abort)) |-> (low_run == RW'(PULSE_CYC))); // R3
    AST_PULSE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RW'(PULSE_CYC));                                          // R3
    AST_HV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_n) && $past(hv_vpp_en) && !$past(abort)) |-> (hv_vpp_en && hv_a9_en)); // R4
    AST_READ_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |-> (!hv_vpp_en && !hv_a9_en && !dq_out_en));      // R6
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PC_W'(MAX_PULSES));                                     // R8
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail) && ((pass || fail) == done));                        // R10
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail) && $stable(pulse_cnt))); // R10
    AST_ABORT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!hv_vpp_en && !hv_a9_en && ce_n && done && fail)); // R11
endmodule

bind erase_seq erase_seq_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .MAX_PULSES (MAX_PULSES),
    .PC_W       (PC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .abort       (abort),
    .hv_vpp_en   (hv_vpp_en),
    .hv_a9_en    (hv_a9_en),
    .vcc_low_sel (vcc_low_sel),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .dq_out_en   (dq_out_en),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .pulse_cnt   (pulse_cnt)
);

// File: tb/sim_erase_seq.sv
`timescale 1ns/1ps
// Bench: builds the expected per-cycle pin trace of each run from the
// requirements into a queue and compares it with the design every cycle.
module sim_erase_seq;
    localparam int AW   = 4;
    localparam int MAXP = 20;
    localparam int NADR = 1 << AW;
    // Interval lengths at 250 MHz, rounded up (R2).
    localparam int N_SU = (20  * 250 + 999) / 1000;
    localparam int N_PW = (400 * 250 + 999) / 1000;
    localparam int N_HD = (12  * 250 + 999) / 1000;
    localparam int N_AV = (250 * 250 + 999) / 1000;
    localparam int N_AN = (120 * 250 + 999) / 1000;

    typedef struct packed {
        logic       vpp; logic a9; logic vlow; logic ce_n; logic oe_n;
        logic       dq_en; logic [7:0] dq; logic [AW-1:0] addr;
        logic       busy; logic done; logic pass; logic fail;
        logic [4:0] pcnt;
    } obs_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
    logic [7:0] dq_in, dq_out;
    logic hv_vpp_en, hv_a9_en, vcc_low_sel, ce_n, oe_n, dq_out_en;
    logic busy, done, pass, fail;
    logic [AW-1:0] addr;
    logic [4:0] pulse_cnt;

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    obs_t q[$];

    // Memory model state.
    int  need [NADR];
    int  weak_addr = -1;
    int  erase_seen = 0;
    logic prev_ce = 1'b1;
    logic model_clr = 1'b0;

    always #2 clk = ~clk;

    erase_seq #(
        .CLK_HZ(250_000_000), .T_PULSE_NS(400), .T_SETUP_NS(20),
        .T_HOLD_NS(12), .T_VACC_NS(250), .T_NACC_NS(120),
        .ADDR_W(AW), .DATA_W(8), .MAX_PULSES(MAXP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .dq_in(dq_in),
        .hv_vpp_en(hv_vpp_en), .hv_a9_en(hv_a9_en), .vcc_low_sel(vcc_low_sel),
        .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .dq_out(dq_out),
        .dq_out_en(dq_out_en), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .pulse_cnt(pulse_cnt)
    );

    // Memory model: counts erase pulses seen with both high voltages on.
    always @(posedge clk) begin
        if (model_clr) erase_seen <= 0;
        else if (!ce_n && prev_ce && hv_vpp_en && hv_a9_en) erase_seen <= erase_seen + 1;
        prev_ce <= ce_n;
    end

    always_comb begin
        if (erase_seen >= need[addr] && !(int'(addr) == weak_addr && !vcc_low_sel))
            dq_in = 8'hFF;
        else
            dq_in = 8'h3C;
    end

    function automatic obs_t mk(bit vpp, bit a9, bit vlow, bit cen, bit oen, bit den,
                                int a, bit bsy, bit dn, bit ps, bit fl, int pc);
        obs_t o;
        o.vpp = vpp; o.a9 = a9; o.vlow = vlow; o.ce_n = cen; o.oe_n = oen;
        o.dq_en = den; o.dq = den ? 8'hFF : 8'h00; o.addr = AW'(a);
        o.busy = bsy; o.done = dn; o.pass = ps; o.fail = fl; o.pcnt = 5'(pc);
        return o;
    endfunction

    function automatic obs_t sample();
        obs_t o;
        o.vpp = hv_vpp_en; o.a9 = hv_a9_en; o.vlow = vcc_low_sel; o.ce_n = ce_n;
        o.oe_n = oe_n; o.dq_en = dq_out_en; o.dq = dq_out; o.addr = addr;
        o.busy = busy; o.done = done; o.pass = pass; o.fail = fail; o.pcnt = pulse_cnt;
        return o;
    endfunction

    task automatic check(obs_t e, string req);
        obs_t g;
        g = sample();
        n_chk++;
        if (g !== e) begin
            n_err++;
            $display("FAIL %s t=%0t got=%h exp=%h", req, $time, g, e);
        end
    endtask

    // Expected trace of one run from the erase algorithm and the model.
    task automatic build(int abort_at);
        int pc, va, outcome, pca;
        bit vok;
        q.delete();
        pc = 0; va = 0; outcome = 0;
        while (outcome == 0) begin
            repeat (N_SU) q.push_back(mk(1,1,0,1,1,1,0,1,0,0,0,pc));
            pc++;
            repeat (N_PW) q.push_back(mk(1,1,0,0,1,1,0,1,0,0,0,pc));
            repeat (N_HD) q.push_back(mk(1,1,0,1,1,1,0,1,0,0,0,pc));
            repeat (N_HD) q.push_back(mk(0,0,1,1,1,0,0,1,0,0,0,pc));
            vok = 0;
            while (1) begin
                repeat (N_AV) q.push_back(mk(0,0,1,0,0,0,va,1,0,0,0,pc));
                if (pc >= need[va]) begin
                    if (va == NADR - 1) begin vok = 1; break; end
                    va++;
                end else break;
            end
            if (vok) begin
                outcome = 1;
                for (int a = 0; a < NADR; a++) begin
                    repeat (N_AN) q.push_back(mk(0,0,0,0,0,0,a,1,0,0,0,pc));
                    if (a == weak_addr) begin outcome = 2; break; end
                end
            end else if (pc == MAXP) outcome = 2;
        end
        if (abort_at >= 0 && abort_at < q.size()) begin
            pca = int'(q[abort_at].pcnt);
            while (q.size() > abort_at + 1) void'(q.pop_back());
            outcome = 2; pc = pca;
        end
        repeat (6) q.push_back(mk(0,0,0,1,1,0,0,0,1,outcome == 1,outcome == 2,pc));
    endtask

    // Start a run and compare every cycle; optional stray start and abort.
    task automatic play(string req, int abort_at, int restart_at);
        @(negedge clk);
        model_clr = 1'b1;
        @(negedge clk);
        model_clr = 1'b0;
        start = 1'b1;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            start = (i == restart_at);
            abort = (i == abort_at);
            check(q[i], req);
        end
        start = 1'b0;
        abort = 1'b0;
    endtask

    task automatic set_need(int v);
        for (int a = 0; a < NADR; a++) need[a] = v;
        weak_addr = -1;
    endtask

    initial begin
        set_need(1);
        repeat (2) @(negedge clk);
        check(mk(0,0,0,1,1,0,0,0,0,0,0,0), "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(mk(0,0,0,1,1,0,0,0,0,0,0,0), "R1 idle");
        end

        // Single pulse erases everything: full phase sequence and pass.
        set_need(1);
        build(-1);
        play("R2 R3 R4 R5 R6 R9", -1, -1);

        // Two slow bytes: retries resume at failing address; stray start ignored.
        set_need(1); need[5] = 3; need[12] = 4;
        build(-1);
        play("R7 R10", -1, 50);

        // One byte never erases: limit reached.
        set_need(1); need[7] = 1000;
        build(-1);
        play("R8", -1, -1);

        // Byte good at reduced supply but bad at normal supply.
        set_need(1); weak_addr = 9;
        build(-1);
        play("R9 final", -1, -1);

        // Abort in the middle of the pulse.
        set_need(1);
        build(N_SU + 40);
        play("R11", N_SU + 40, -1);

        // New start after a failed run clears flags and passes again.
        set_need(2);
        build(-1);
        play("R10 restart", -1, -1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog R1..: run did not finish got=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule